// File: doc/BRIEF.md
# MMU Fault Status Capture Register

This block sits beside a memory management unit and keeps the record of the most recent access fault. Each time the translation logic pulses its fault strobe, the block builds a 32-bit status word from the kind of access that failed: write, execute, supervisor or alternate space. It also stores the failing address. If software has not yet consumed the previous status, the new word carries an overflow flag. Software reaches both registers through a small register port. A read of the status register clears it, which arms the overflow detector again.

The block also decides whether the fault becomes a trap. A trap is raised only when translation is enabled and the no-fault mode is off. An execute fault raises an instruction access trap. Every other fault raises a data access trap. Each trap is a single-cycle pulse.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset the status register, the address register, the read data and both trap outputs are all zero.
- R2: A fault loads status with bit 1 set, the code 5 in bits 4:2, bit 5 equal to the supervisor qualifier, bit 6 equal to the execute qualifier, bit 7 equal to the write qualifier and bit 16 equal to the alternate-space qualifier. The new value is visible in the cycle after the strobe.
- R3: If the status is nonzero when a fault arrives, the result is 1 ORed with the new fault word (bit 0 marks overflow). A fault that arrives on a zero status leaves bit 0 clear.
- R4: A fault loads the address register with the fault address in the cycle after the strobe.
- R5: A read with regSel = 0 returns the status value on regRdData one cycle later, and the status becomes zero. regRdData holds its value until the next read.
- R6: A read with regSel = 1 returns the fault address one cycle later and leaves the status unchanged.
- R7: A trap pulse occurs only for a fault with mmuEnable = 1 and noFaultMode = 0. Otherwise both trap outputs stay low.
- R8: A trapping fault with the execute qualifier set pulses instTrap for exactly one cycle, in the cycle after the strobe. Any other trapping fault pulses dataTrap in the same way. The two trap outputs are never high together.
- R9: When a fault and a status read occur in the same cycle, the fault update wins. The read returns the value held before the fault, and the status holds the new fault word, with overflow if the earlier value was nonzero.
- R10: A software write with regSel = 0 loads status, and one with regSel = 1 loads the address register. A write wins over a read clear in the same cycle. A fault in the same cycle wins over the write.
- R11: With no fault, read or write, the status and address registers keep their values and both traps stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultStrobe | input | 1 | One-cycle pulse reporting a failed access |
| faultAddr | input | ADDR_W | Address of the failed access |
| faultWrite | input | 1 | Failed access was a write |
| faultExec | input | 1 | Failed access was an instruction fetch |
| faultSuper | input | 1 | Failed access was made in supervisor mode |
| faultAlt | input | 1 | Failed access used an alternate address space |
| mmuEnable | input | 1 | Translation enable bit from the MMU control register |
| noFaultMode | input | 1 | No-fault bit from the MMU control register |
| regRdEn | input | 1 | Register read request |
| regWrEn | input | 1 | Register write request |
| regSel | input | 1 | 0 selects status, 1 selects the fault address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, registered, one cycle after the request |
| statusOut | output | DATA_W | Current fault status register |
| addrOut | output | ADDR_W | Current fault address register |
| instTrap | output | 1 | Instruction access trap pulse |
| dataTrap | output | 1 | Data access trap pulse |

## Verification
Assertions check on every cycle that the fixed fields and the qualifier bits land in status after a strobe. They also check when the overflow bit is set and when it is not, that the address is captured, that a status read clears the register, and that an address read leaves it alone. The trap checks cover gating by enable and no-fault, the choice of trap kind, and that the two traps never fire together. Only the bench scenarios show the collisions: a fault against a read, a fault against a write, and a write against a read clear. The bench also shows what value a colliding read returns, that read data holds between reads, and how sequences of faults, reads and writes build and clear overflow.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  // Status bit positions: software decodes these, so they are fixed.
  localparam int ST_OVF_BIT   = 0;
  localparam int ST_AV_BIT    = 1;
  localparam int ST_TYPE_LO   = 2;
  localparam int ST_SUPER_BIT = 5;
  localparam int ST_EXEC_BIT  = 6;
  localparam int ST_WRITE_BIT = 7;
  localparam int ST_ALT_BIT   = 16;
  localparam logic [2:0] ST_TYPE_CODE = 3'd5;

  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_ADDR   = 1'b1;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capFault;
    logic markOvf;
    logic loadStatus;
    logic clearStatus;
    logic loadAddr;
    logic latchRead;
  } fsrStrobe_t;

endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       faultStrobe,
  input  logic       faultExec,
  input  logic       mmuEnable,
  input  logic       noFaultMode,
  input  logic       regRdEn,
  input  logic       regWrEn,
  input  logic       regSel,
  input  logic       statusBusy,
  output fsrStrobe_t strobes,
  output logic       instTrap,
  output logic       dataTrap
);

  logic trapArm;

  // Priority: fault update, then software write, then read clear.
  always_comb begin
    strobes             = '0;
    strobes.capFault    = faultStrobe;
    strobes.markOvf     = faultStrobe && statusBusy;
    strobes.loadStatus  = !faultStrobe && regWrEn && (regSel == SEL_STATUS);
    strobes.loadAddr    = !faultStrobe && regWrEn && (regSel == SEL_ADDR);
    strobes.clearStatus = !faultStrobe && !regWrEn && regRdEn && (regSel == SEL_STATUS);
    strobes.latchRead   = regRdEn;
  end

  assign trapArm = faultStrobe && mmuEnable && !noFaultMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instTrap <= 1'b0;
      dataTrap <= 1'b0;
    end else begin
      instTrap <= trapArm && faultExec;
      dataTrap <= trapArm && !faultExec;
    end
  end

  // R7: a trap pulse needs an enabled, non-no-fault strobe one cycle earlier
  p_trap_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (instTrap || dataTrap) |-> $past(faultStrobe && mmuEnable && !noFaultMode));

  // R7: a suppressed fault produces no trap
  p_trap_suppress_r7: assert property (@(posedge clk) disable iff (!rstN)
    (faultStrobe && (!mmuEnable || noFaultMode)) |=> !(instTrap || dataTrap));

  // R8: trap kind follows the execute qualifier
  p_trap_kind_r8: assert property (@(posedge clk) disable iff (!rstN)
    (faultStrobe && mmuEnable && !noFaultMode) |=> (instTrap == $past(faultExec)) && (dataTrap == !$past(faultExec)));

  // R8: never both traps
  p_trap_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({instTrap, dataTrap}));

endmodule

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  fsrStrobe_t        strobes,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              faultWrite,
  input  logic              faultExec,
  input  logic              faultSuper,
  input  logic              faultAlt,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] statusReg,
  output logic [ADDR_W-1:0] addrReg,
  output logic [DATA_W-1:0] rdData,
  output logic              statusBusy
);

  logic [DATA_W-1:0] faultWord;
  logic [DATA_W-1:0] addrView;
  logic [ADDR_W-1:0] wrAsAddr;
  logic [DATA_W-1:0] rdSource;

  // Fit the address register to the data width in both directions.
  generate
    if (ADDR_W >= DATA_W) begin : g_wideAddr
      assign addrView = addrReg[DATA_W-1:0];
      if (ADDR_W > DATA_W) begin : g_pad
        assign wrAsAddr = {{(ADDR_W-DATA_W){1'b0}}, regWrData};
      end else begin : g_same
        assign wrAsAddr = regWrData;
      end
    end else begin : g_narrowAddr
      assign addrView = {{(DATA_W-ADDR_W){1'b0}}, addrReg};
      assign wrAsAddr = regWrData[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    faultWord                               = '0;
    faultWord[ST_OVF_BIT]                   = strobes.markOvf;
    faultWord[ST_AV_BIT]                    = 1'b1;
    faultWord[ST_TYPE_LO +: 3]              = ST_TYPE_CODE;
    faultWord[ST_SUPER_BIT]                 = faultSuper;
    faultWord[ST_EXEC_BIT]                  = faultExec;
    faultWord[ST_WRITE_BIT]                 = faultWrite;
    faultWord[ST_ALT_BIT]                   = faultAlt;
  end

  assign statusBusy = |statusReg;
  assign rdSource   = (regSel == SEL_ADDR) ? addrView : statusReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
    end else if (strobes.capFault) begin
      statusReg <= faultWord;
    end else if (strobes.loadStatus) begin
      statusReg <= regWrData;
    end else if (strobes.clearStatus) begin
      statusReg <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strobes.capFault) begin
      addrReg <= faultAddr;
    end else if (strobes.loadAddr) begin
      addrReg <= wrAsAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.latchRead) begin
      rdData <= rdSource;
    end
  end

  // R2: fixed fields present after every fault
  p_fields_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capFault |=> statusReg[ST_AV_BIT] && (statusReg[ST_TYPE_LO +: 3] == ST_TYPE_CODE));

  // R2: qualifier bits mirror the faulting access
  p_qual_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capFault |=> (statusReg[ST_WRITE_BIT] == $past(faultWrite)) &&
                         (statusReg[ST_EXEC_BIT]  == $past(faultExec))  &&
                         (statusReg[ST_SUPER_BIT] == $past(faultSuper)) &&
                         (statusReg[ST_ALT_BIT]   == $past(faultAlt)));

  // R3: unread status marks overflow
  p_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capFault && (statusReg != '0)) |=> statusReg[ST_OVF_BIT]);

  // R3: empty status gives no overflow
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capFault && (statusReg == '0)) |=> !statusReg[ST_OVF_BIT]);

  // R4: fault address captured
  p_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capFault |=> addrReg == $past(faultAddr));

  // R5: status read returns the value held
  p_read_value_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchRead && regSel == SEL_STATUS) |=> rdData == $past(statusReg));

  // R5: status read with nothing competing clears the register
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearStatus |=> statusReg == '0);

  // R6: address read leaves status alone
  p_addr_read_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchRead && regSel == SEL_ADDR && !strobes.capFault && !strobes.loadStatus) |=> $stable(statusReg));

endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultStrobe,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              faultWrite,
  input  logic              faultExec,
  input  logic              faultSuper,
  input  logic              faultAlt,
  input  logic              mmuEnable,
  input  logic              noFaultMode,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] statusOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              instTrap,
  output logic              dataTrap
);

  fsrStrobe_t strobes;
  logic       statusBusy;

  fsr_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .faultStrobe (faultStrobe),
    .faultExec   (faultExec),
    .mmuEnable   (mmuEnable),
    .noFaultMode (noFaultMode),
    .regRdEn     (regRdEn),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .statusBusy  (statusBusy),
    .strobes     (strobes),
    .instTrap    (instTrap),
    .dataTrap    (dataTrap)
  );

  fsr_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .faultAddr  (faultAddr),
    .faultWrite (faultWrite),
    .faultExec  (faultExec),
    .faultSuper (faultSuper),
    .faultAlt   (faultAlt),
    .regSel     (regSel),
    .regWrData  (regWrData),
    .statusReg  (statusOut),
    .addrReg    (addrOut),
    .rdData     (regRdData),
    .statusBusy (statusBusy)
  );

endmodule

// File: tb/mmu_fault_capture_bench.sv
`timescale 1ns/1ps
module mmu_fault_capture_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultStrobe = 1'b0;
  logic [31:0] faultAddr = '0;
  logic        faultWrite = 1'b0, faultExec = 1'b0, faultSuper = 1'b0, faultAlt = 1'b0;
  logic        mmuEnable = 1'b0, noFaultMode = 1'b0;
  logic        regRdEn = 1'b0, regWrEn = 1'b0, regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData, statusOut, addrOut;
  logic        instTrap, dataTrap;

  always #2.5 clk = ~clk;

  mmu_fault_capture u_mmu_fault_capture (
    .clk(clk), .rstN(rstN), .faultStrobe(faultStrobe), .faultAddr(faultAddr),
    .faultWrite(faultWrite), .faultExec(faultExec), .faultSuper(faultSuper), .faultAlt(faultAlt),
    .mmuEnable(mmuEnable), .noFaultMode(noFaultMode), .regRdEn(regRdEn), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData), .statusOut(statusOut),
    .addrOut(addrOut), .instTrap(instTrap), .dataTrap(dataTrap)
  );

  typedef struct packed {
    logic [31:0] st;
    logic [31:0] ad;
    logic [31:0] rd;
    logic        it;
    logic        dt;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int       tgtQ[$];

  int checks = 0;
  int errors = 0;
  int posCount = 0;
  bit finished = 1'b0;

  // Bench model state, built from the requirements.
  logic [31:0] mStatus = '0, mAddr = '0, mRd = '0;

  always @(posedge clk) posCount <= posCount + 1;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(bit f, logic [31:0] fa, bit w, bit x, bit s, bit a,
                      bit en, bit nf, bit rd, bit wr, bit sel, logic [31:0] wd, string tag);
    expItem_t e;
    logic [31:0] word;
    @(negedge clk);
    faultStrobe = f; faultAddr = fa; faultWrite = w; faultExec = x; faultSuper = s; faultAlt = a;
    mmuEnable = en; noFaultMode = nf; regRdEn = rd; regWrEn = wr; regSel = sel; regWrData = wd;
    if (rd) mRd = sel ? mAddr : mStatus;
    if (f) begin
      word = 32'h0000_0016 | (s ? 32'h20 : 32'h0) | (x ? 32'h40 : 32'h0) |
             (w ? 32'h80 : 32'h0) | (a ? 32'h1_0000 : 32'h0) | ((mStatus != 0) ? 32'h1 : 32'h0);
      mStatus = word;
      mAddr   = fa;
    end else begin
      if (wr && !sel)       mStatus = wd;
      else if (rd && !sel)  mStatus = '0;
      if (wr && sel)        mAddr = wd;
    end
    e.st = mStatus; e.ad = mAddr; e.rd = mRd;
    e.it = f && en && !nf && x;
    e.dt = f && en && !nf && !x;
    expQ.push_back(e);
    tagQ.push_back(tag);
    tgtQ.push_back(posCount + 1);
  endtask

  task automatic idle(string tag);
    step(0, 32'h0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 32'h0, tag);
  endtask

  // Monitor: pops expected items once their cycle has passed.
  initial begin
    forever begin
      @(negedge clk);
      while (tgtQ.size() > 0 && tgtQ[0] <= posCount) begin
        expItem_t e;
        string    t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        void'(tgtQ.pop_front());
        cmp(t, "status", statusOut, e.st);
        cmp(t, "addr",   addrOut,   e.ad);
        cmp(t, "rddata", regRdData, e.rd);
        cmp(t, "instTrap", {31'b0, instTrap}, {31'b0, e.it});
        cmp(t, "dataTrap", {31'b0, dataTrap}, {31'b0, e.dt});
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    cmp("R1", "status", statusOut, 32'h0);
    cmp("R1", "addr",   addrOut,   32'h0);
    cmp("R1", "rddata", regRdData, 32'h0);
    cmp("R1", "traps",  {30'b0, instTrap, dataTrap}, 32'h0);

    // R2 R8: supervisor data write fault, data trap, status 0xB6
    step(1, 32'h1000_0040, 1, 0, 1, 0, 1, 0, 0, 0, 0, 32'h0, "R2");
    idle("R8");
    // R5: read status returns 0xB6 and clears
    step(0, 32'h0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 32'h0, "R5");
    idle("R5");
    // R2 R8: user execute alternate-space fault, instruction trap, 0x10056
    step(1, 32'h2000_0100, 0, 1, 0, 1, 1, 0, 0, 0, 0, 32'h0, "R2");
    idle("R11");
    // R3: second unread fault sets overflow, 0x97
    step(1, 32'h3000_0008, 1, 0, 0, 0, 1, 0, 0, 0, 0, 32'h0, "R3");
    idle("R11");
    // R6: address read keeps status
    step(0, 32'h0, 0, 0, 0, 0, 1, 0, 1, 0, 1, 32'h0, "R6");
    idle("R6");
    // R5: clear, then R4/R7 with no-fault mode: no trap, no overflow
    step(0, 32'h0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 32'h0, "R5");
    step(1, 32'h4444_0004, 0, 0, 1, 0, 1, 1, 0, 0, 0, 32'h0, "R7");
    idle("R4");
    // R7: translation disabled, execute fault, no trap
    step(1, 32'h5555_0000, 0, 1, 0, 0, 0, 0, 0, 0, 0, 32'h0, "R7");
    idle("R7");
    // R9: fault and status read collide
    step(1, 32'h6666_0010, 0, 0, 0, 1, 1, 0, 1, 0, 0, 32'h0, "R9");
    idle("R9");
    step(0, 32'h0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 32'h0, "R9");
    // R9: collision on empty status gives no overflow
    step(1, 32'h7777_0020, 1, 0, 1, 0, 1, 0, 1, 0, 0, 32'h0, "R9");
    idle("R9");
    // R10: software writes
    step(0, 32'h0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 32'hA5A5_0000, "R10");
    step(0, 32'h0, 0, 0, 0, 0, 1, 0, 0, 1, 1, 32'h1234_5678, "R10");
    step(0, 32'h0, 0, 0, 0, 0, 1, 0, 1, 1, 0, 32'h0000_0000, "R10");
    step(1, 32'h8888_0000, 0, 1, 1, 0, 1, 0, 0, 1, 0, 32'hFFFF_FFFF, "R10");
    step(1, 32'h9999_0000, 0, 0, 0, 0, 1, 0, 0, 1, 1, 32'hDEAD_BEEF, "R10");
    step(0, 32'h0, 0, 0, 0, 0, 1, 0, 1, 0, 1, 32'h0, "R6");
    repeat (3) idle("R11");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule